// File: doc/BRIEF.md
# Flow-Through Zero-Turnaround Synchronous SRAM

This block is a small synchronous static memory whose read path is flow-through. An address captured on a rising clock edge produces its read data combinationally in the cycle right after that edge. Write data arrives in that same slot: one cycle after its address. Because reads and writes both use the cycle after the address edge, any mix of reads and writes can follow each other on consecutive clocks, and data moves on every clock with no turnaround gap.

Writes are held in a one-entry pending buffer for one enabled cycle before they reach the array. A read that hits the pending entry gets the new bytes merged over the old array word. A burst mode steps the low two address bits in linear or interleaved order. A clock enable freezes the whole pipeline. The bus driver enable is sequenced internally and is also gated by an asynchronous output enable. The array depth and the byte-lane geometry are parameters. The default is 256 words of four 9-bit lanes.

Top module: `fts_sram`

## Requirements
- R1: When `clk_en` is 1, the inputs are sampled on the rising edge. A selected read loaded at an edge shows the addressed word on `dout`, with `dout_en` high, during the cycle that follows that edge.
- R2: When `clk_en` is 0 at an edge, that edge is ignored. The address, the operation in progress, the pending write, the array and `dout` all keep their values.
- R3: Reads and writes may alternate on consecutive enabled clocks with no idle cycle. The write data for an address loaded at one edge is driven on `din` during the following cycle and is captured at the next enabled edge.
- R4: A write updates lane i (bits i*LANE_W to i*LANE_W+LANE_W-1) only when `lane_n[i]` was 0 in the address cycle of that beat. All other lanes keep their contents.
- R5: A load cycle (`adv`=0) is selected only when `sel1_n`=0, `sel2`=1 and `sel3_n`=0. Any other combination is a deselect: no access takes place, and `dout_en` is 0 in the following cycle.
- R6: In the cycle that carries write data, `dout_en` is 0.
- R7: When `oe_n` is 1, `dout_en` is 0 in the same cycle. `oe_n` has no effect on any stored state.
- R8: When `adv` is 1, the previous operation continues as the next burst beat. `wr_n` and the select inputs are ignored, and the address bits above the low two are unchanged. After a deselect, `adv`=1 stays deselected.
- R9: `order` is sampled in the load cycle. With `order`=0 (linear), beat k uses low bits (start+k) mod 4. With `order`=1 (interleaved), beat k uses start XOR k.
- R10: A read to the address of a write whose data was captured at the same edge returns that new data in the written lanes and the array contents in the other lanes.
- R11: A synchronous reset (`rst_n`=0) clears the operation in progress and the pending write, so `dout_en` is 0 after reset. The array contents are not reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_en | input | 1 | Clock enable; 0 stalls the whole block |
| addr | input | ADDR_W | Word address, used in load cycles |
| wr_n | input | 1 | 0 = write, 1 = read, used in load cycles |
| lane_n | input | LANES | Per-lane write selects, active low, sampled every beat |
| sel1_n | input | 1 | Chip select, active low |
| sel2 | input | 1 | Chip select, active high |
| sel3_n | input | 1 | Chip select, active low |
| adv | input | 1 | 1 = advance the burst, 0 = load a new address |
| order | input | 1 | Burst order for a load: 0 linear, 1 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| din | input | LANES*LANE_W | Write data, driven in the cycle after the address |
| dout | output | LANES*LANE_W | Read data, flow-through |
| dout_en | output | 1 | Bus drive enable for `dout` |

## Verification
The bench goes after a read that immediately follows a write to the same address. A design that read only the array would return stale bytes there, and one that ignored the lane mask would overwrite the unselected lanes with the pending word. Both burst orders are walked from a start address whose low bits are not zero. An adder used in place of the XOR, or a carry into the upper address bits, would then fetch the wrong words. Stalls are placed inside bursts and between a write address and its data: a design that let anything move while stalled would skip a beat or capture the wrong write data. The bench also checks deselect, advance after a deselect, and `oe_n` gating, where a wrong design would drive the bus in a cycle that belongs to write data or to no access.

// File: rtl/fts_sram.sv
module fts_sram #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_n,
  input  logic [LANES-1:0]  lane_n,
  input  logic              sel1_n,
  input  logic              sel2,
  input  logic              sel3_n,
  input  logic              adv,
  input  logic              order,
  input  logic              oe_n,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);

  typedef enum logic [1:0] {OP_IDLE, OP_RD, OP_WR} op_t;

  logic [DATA_W-1:0] mem [DEPTH];

  op_t               op_q;
  logic [ADDR_W-1:0] cur_addr;
  logic [1:0]        base_lo, cnt;
  logic              ord_q;
  logic [LANES-1:0]  mask_q;

  logic              pend_v;
  logic [ADDR_W-1:0] pend_a;
  logic [LANES-1:0]  pend_m;
  logic [DATA_W-1:0] pend_d;

  wire       selected = !sel1_n && sel2 && !sel3_n;
  wire [1:0] cnt_n    = cnt + 2'd1;
  wire [1:0] lo_n     = ord_q ? (base_lo ^ cnt_n) : (base_lo + cnt_n);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q     <= OP_IDLE;
      cur_addr <= '0;
      base_lo  <= '0;
      cnt      <= '0;
      ord_q    <= 1'b0;
      mask_q   <= '0;
      pend_v   <= 1'b0;
      pend_a   <= '0;
      pend_m   <= '0;
      pend_d   <= '0;
    end else if (clk_en) begin
      pend_v <= (op_q == OP_WR);
      if (op_q == OP_WR) begin
        pend_a <= cur_addr;
        pend_m <= mask_q;
        pend_d <= din;
      end
      if (!adv) begin
        if (selected) begin
          op_q     <= wr_n ? OP_RD : OP_WR;
          cur_addr <= addr;
          base_lo  <= addr[1:0];
          cnt      <= '0;
          ord_q    <= order;
          mask_q   <= ~lane_n;
        end else begin
          op_q <= OP_IDLE;
        end
      end else if (op_q != OP_IDLE) begin
        cnt           <= cnt_n;
        cur_addr[1:0] <= lo_n;
        mask_q        <= ~lane_n;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && clk_en && pend_v) begin
      for (int i = 0; i < LANES; i++)
        if (pend_m[i])
          mem[pend_a][i*LANE_W +: LANE_W] <= pend_d[i*LANE_W +: LANE_W];
    end
  end

  always_comb begin
    dout = mem[cur_addr];
    if (pend_v && pend_a == cur_addr)
      for (int i = 0; i < LANES; i++)
        if (pend_m[i]) dout[i*LANE_W +: LANE_W] = pend_d[i*LANE_W +: LANE_W];
  end

  assign dout_en = (op_q == OP_RD) && !oe_n;

  a_r5_deselect_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !adv && !selected) |=> !dout_en);

  a_r6_write_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !adv && selected && !wr_n) |=> !dout_en);

  a_r7_oe_gates: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dout_en);

  a_r2_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> ($stable(cur_addr) && $stable(op_q) && $stable(pend_v) && $stable(pend_d)));

  a_r8_burst_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && adv) |=> (cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2])));

endmodule

// File: tb/tb_fts_sram.sv
module tb_fts_sram;
  localparam int ADDR_W = 8;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int DATA_W = LANES * LANE_W;

  logic clk = 0, rst_n = 0, clk_en = 1;
  logic [ADDR_W-1:0] addr = '0;
  logic wr_n = 1, sel1_n = 1, sel2 = 0, sel3_n = 1, adv = 0, order = 0, oe_n = 0;
  logic [LANES-1:0] lane_n = '1;
  logic [DATA_W-1:0] din = '0, dout;
  logic dout_en;

  fts_sram #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) dut (
    .clk, .rst_n, .clk_en, .addr, .wr_n, .lane_n, .sel1_n, .sel2, .sel3_n,
    .adv, .order, .oe_n, .din, .dout, .dout_en);

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  string tag = "R11";

  // behavioural reference
  logic [DATA_W-1:0] ref_mem [int];
  int m_op = 0;               // 0 idle, 1 read, 2 write
  int m_addr = 0, m_base = 0, m_cnt = 0, m_ord = 0;
  logic [LANES-1:0] m_mask = '0;
  bit pv = 0; int pa = 0; logic [LANES-1:0] pm = '0; logic [DATA_W-1:0] pd = '0;

  function automatic logic [DATA_W-1:0] merge(logic [DATA_W-1:0] old, logic [DATA_W-1:0] nw,
                                              logic [LANES-1:0] m);
    logic [DATA_W-1:0] r = old;
    for (int i = 0; i < LANES; i++)
      if (m[i]) r[i*LANE_W +: LANE_W] = nw[i*LANE_W +: LANE_W];
    return r;
  endfunction

  task automatic compare();
    bit e_en = (m_op == 1) && !oe_n;
    checks++;
    if (dout_en !== e_en) begin
      fails++;
      $display("FAIL %s: dout_en=%0b expected %0b", tag, dout_en, e_en);
    end
    if (e_en && ref_mem.exists(m_addr)) begin
      logic [DATA_W-1:0] e = ref_mem[m_addr];
      if (pv && pa == m_addr) e = merge(e, pd, pm);
      checks++;
      if (dout !== e) begin
        fails++;
        $display("FAIL %s: addr %0d dout=%h expected %h", tag, m_addr, dout, e);
      end
    end
  endtask

  task automatic model_edge();
    if (!rst_n) begin m_op = 0; pv = 0; return; end
    if (!clk_en) return;
    if (pv) ref_mem[pa] = merge(ref_mem.exists(pa) ? ref_mem[pa] : '0, pd, pm);
    pv = (m_op == 2);
    if (m_op == 2) begin pa = m_addr; pm = m_mask; pd = din; end
    if (!adv) begin
      if (!sel1_n && sel2 && !sel3_n) begin
        m_op = wr_n ? 1 : 2; m_addr = addr; m_base = addr % 4; m_cnt = 0;
        m_ord = order; m_mask = ~lane_n;
      end else m_op = 0;
    end else if (m_op != 0) begin
      m_cnt = (m_cnt + 1) % 4;
      m_addr = (m_addr / 4) * 4 + (m_ord ? (m_base ^ m_cnt) : ((m_base + m_cnt) % 4));
      m_mask = ~lane_n;
    end
  endtask

  task automatic tick();
    if (m_op == 2) din = {$urandom, $urandom};
    #1 compare();
    @(posedge clk);
    model_edge();
    #1;
  endtask

  task automatic go(bit ce, bit a, bit s1n, bit s2, bit s3n, bit w_n,
                    int ad, logic [LANES-1:0] ln, bit ord, bit oen);
    clk_en = ce; adv = a; sel1_n = s1n; sel2 = s2; sel3_n = s3n; wr_n = w_n;
    addr = ad[ADDR_W-1:0]; lane_n = ln; order = ord; oe_n = oen;
    tick();
  endtask

  task automatic rd(int ad);  go(1, 0, 0, 1, 0, 1, ad, '1, 0, 0); endtask
  task automatic wr(int ad, logic [LANES-1:0] ln); go(1, 0, 0, 1, 0, 0, ad, ln, 0, 0); endtask
  task automatic nop();       go(1, 0, 1, 0, 1, 1, 0, '1, 0, 0); endtask
  task automatic burst(bit ord); go(1, 1, 1, 0, 1, 1, 0, '1, ord, 0); endtask

  initial begin
    #2;
    tag = "R11";
    repeat (3) tick();
    rst_n = 1;
    nop();
    tag = "R11 reset idle"; nop();

    tag = "R3 fill back to back";
    for (int a = 0; a < 256; a++) wr(a, '0);
    nop(); nop();

    tag = "R1 read flow-through";
    rd(5); rd(200); rd(17); nop();

    tag = "R3 alternate";
    wr(30, '0); rd(31); wr(32, '0); rd(30); rd(32); nop();

    tag = "R10 read after pending write";
    wr(10, 4'b1010); rd(10); rd(10); nop();

    tag = "R4 lane mask";
    wr(40, 4'b0110); nop(); rd(40); wr(41, 4'b1111); rd(41); nop();

    tag = "R9 linear burst";
    rd(6); burst(0); burst(0); burst(0); burst(0); nop();
    tag = "R9 interleaved burst";
    go(1, 0, 0, 1, 0, 1, 7, '1, 1, 0); burst(0); burst(1); burst(0); nop();

    tag = "R8 burst write ignores selects";
    wr(13, '0); go(1, 1, 1, 1, 1, 1, 99, '0, 0, 0); go(1, 1, 0, 0, 0, 1, 99, 4'b0011, 0, 0);
    go(1, 1, 1, 0, 1, 0, 99, '0, 0, 0);
    tag = "R8 readback";
    go(1, 0, 0, 1, 0, 1, 12, '1, 1, 0); burst(1); burst(1); burst(1); nop();
    tag = "R8 advance after deselect";
    nop(); burst(0); burst(0); nop();

    tag = "R2 stall in burst";
    rd(20); go(0, 1, 0, 1, 0, 0, 3, '0, 1, 0); go(0, 0, 1, 0, 1, 0, 9, '0, 0, 0);
    burst(0); burst(0); nop();
    tag = "R2 stall before write data";
    wr(50, '0); go(0, 0, 0, 1, 0, 1, 51, '1, 0, 0); go(0, 0, 0, 1, 0, 1, 51, '1, 0, 0);
    rd(50); nop();

    tag = "R5 deselect";
    go(1, 0, 1, 1, 0, 1, 5, '1, 0, 0); go(1, 0, 0, 0, 0, 1, 5, '1, 0, 0);
    go(1, 0, 0, 1, 1, 1, 5, '1, 0, 0); go(1, 0, 0, 1, 0, 0, 5, '0, 0, 0);
    tag = "R6 write cycle"; nop(); nop();

    tag = "R7 output enable";
    go(1, 0, 0, 1, 0, 1, 8, '1, 0, 1); go(1, 1, 0, 1, 0, 1, 8, '1, 0, 1);
    go(1, 1, 0, 1, 0, 1, 8, '1, 0, 0); nop();

    tag = "R1 R3 R4 R9 mixed traffic";
    for (int n = 0; n < 3000; n++) begin
      int r = $urandom % 100;
      go(($urandom % 10) != 0, ($urandom % 3) == 0, ($urandom % 8) == 0, 1,
         ($urandom % 8) == 0, $urandom % 2, $urandom % 256, $urandom, $urandom % 2, r < 8);
    end
    nop(); nop();

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule